// File: doc/BRIEF.md
# SMBus Slave Command Decoder

This block sits behind a bit-level SMBus engine and turns its decoded events (start or repeated start, stop, received byte) into register-space actions. The first byte after a start is the address byte; when it carries this slave's 7-bit address, bit 0 picks the direction. In a write, the next byte is the command byte, and any bytes after it are data bytes. The block decides ACK or NACK for every byte it owns. It keeps a RAM pointer and an EEPROM pointer, writes RAM bytes, and issues pointer-set, page-erase and byte-program requests to an EEPROM controller.

What a write means depends on three things: the command range, the number of data bytes that were ACKed, and two mode inputs. It is therefore resolved only when the transaction ends, at the stop or repeated start that closes it.
- RAM-range command, no data: sets the RAM pointer.
- RAM-range command, one data byte: writes a RAM byte.
- EEPROM-range command, one data byte: sets the EEPROM pointer.
- EEPROM-range command, two data bytes: erases a page or programs a byte, as selected by the erase mode.

Anything cut short, or anything that drew a NACK, has no effect.

The control is an enumerated state machine with these states:
- `PH_IDLE`: no transaction.
- `PH_ADDR`: waiting for the address byte.
- `PH_CMD`: waiting for the command byte.
- `PH_DATA`: collecting data bytes.
- `PH_READ`: a read is in progress and the return path is elsewhere.
- `PH_SKIP`: ignore all bytes until the next start.

Its transitions are:
- A start, from any state, goes to `PH_ADDR`.
- A stop, from any state, goes to `PH_IDLE`.
- In `PH_ADDR`, a matching address byte goes to `PH_CMD` (write) or `PH_READ` (read); a mismatch goes to `PH_SKIP`.
- In `PH_CMD`, an accepted command goes to `PH_DATA`; a rejected one goes to `PH_SKIP`.
- In `PH_DATA`, an accepted byte stays in `PH_DATA`; a rejected one goes to `PH_SKIP`.
- Leaving `PH_DATA` on a start or stop commits the collected operation.

Top module: `smb_cmd_decoder`

## Requirements
- R1: An address byte is ACKed only when bits 7:1 equal SLAVE_ADDR. Bit 0 = 0 starts a write and bit 0 = 1 starts a read. A mismatch is NACKed, and every byte up to the next start then gets no response and causes no action.
- R2: Each byte received in `PH_ADDR`, `PH_CMD` or `PH_DATA` produces exactly one `resp_valid` pulse, one cycle after the byte event, with `resp_ack` = 1 for ACK. Bytes seen in `PH_IDLE`, `PH_READ` or `PH_SKIP` produce no response.
- R3: A command byte in 00h–6Fh followed directly by stop or repeated start loads `ram_ptr` with the command's low 7 bits and clears `ptr_is_ee`.
- R4: A command byte in 00h–6Fh with exactly one data byte gives one `ram_we` pulse at the terminating stop or repeated start, with `ram_waddr` = command and `ram_wdata` = data. A second data byte is NACKed and cancels the transaction.
- R5: A command byte in 80h–9Fh with exactly one data byte loads `ee_ptr` = {command − 80h (5 bits), data}, pulses `ee_ptr_set`, sets `ptr_is_ee`, and copies `mode_follow` into `rd_follow`.
- R6: A command byte in 80h–9Fh with two data bytes and `mode_erase` = 1 pulses `ee_erase`, with `ee_op_addr` = the addressed location with its low 6 bits cleared, which is the page base.
- R7: The same transaction with `mode_erase` = 0 pulses `ee_prog`, with `ee_op_addr` = {command − 80h, first data byte} and `ee_op_data` = second data byte.
- R8: A third data byte after an EEPROM-range command is NACKed and cancels the transaction.
- R9: A command byte in 70h–7Fh or A0h–FFh is NACKed and changes no pointer and issues no request.
- R10: While `ee_busy` = 1, an EEPROM-range command byte or data byte is NACKed and cancels the transaction. RAM-range transactions are unaffected.
- R11: A repeated start after a pointer-setting write commits that pointer and opens a new address phase. The read that follows leaves the pointer unchanged.
- R12: A stop that ends an EEPROM-range write before its first data byte changes nothing.
- R13: Request outputs (`ram_we`, `ee_ptr_set`, `ee_erase`, `ee_prog`) are single-cycle pulses, at most one per cycle. They come only from a terminating stop or start, and the pointer outputs change only together with their own set event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start | input | 1 | Start or repeated start seen (one-cycle pulse) |
| ev_stop | input | 1 | Stop seen (one-cycle pulse) |
| ev_byte | input | 1 | A whole byte was received (one-cycle pulse) |
| rx_byte | input | 8 | Received byte, valid with ev_byte |
| mode_follow | input | 1 | Config mode: read follows an EEPROM pointer set by repeated start |
| mode_erase | input | 1 | Config mode: two-data-byte EEPROM write means page erase |
| ee_busy | input | 1 | EEPROM controller is erasing |
| resp_valid | output | 1 | Response decided for the previous byte |
| resp_ack | output | 1 | 1 = ACK, 0 = NACK |
| ram_we | output | 1 | RAM write strobe |
| ram_waddr | output | RAM_AW | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| ram_ptr | output | RAM_AW | Current RAM pointer |
| ee_ptr | output | EE_AW | Current EEPROM pointer |
| ee_ptr_set | output | 1 | EEPROM pointer set request |
| ptr_is_ee | output | 1 | Last pointer set targeted EEPROM space |
| rd_follow | output | 1 | Follow-on-read mode recorded with the EEPROM pointer |
| ee_erase | output | 1 | Page erase request |
| ee_prog | output | 1 | Byte program request |
| ee_op_addr | output | EE_AW | Address for erase or program |
| ee_op_data | output | 8 | Data for program |

## Verification
The bench overrides SLAVE_ADDR to 2Eh so that an address match cannot come from the default value, and it keeps the default ranges 00h–6Fh and 80h–9Fh with a 6-bit page offset. These values place the range edges 6Fh/70h, 7Fh/80h and 9Fh/A0h, and a page base that differs from the addressed byte, within a few directed transactions. With them, every count-dependent meaning of a write can be tried under both settings of the erase mode, with and without the busy input, and with both stop and repeated start as the terminator.

// File: rtl/smb_cmd_pkg.sv
package smb_cmd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_DATA,
        PH_READ,
        PH_SKIP
    } phase_t;

    typedef enum logic [1:0] {
        CK_RAM,
        CK_EE,
        CK_BAD
    } cmd_kind_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_RAM_PTR,
        OP_RAM_WR,
        OP_EE_PTR,
        OP_EE_ERASE,
        OP_EE_PROG
    } op_t;

endpackage

// File: rtl/smb_cmd_classify.sv
module smb_cmd_classify
    import smb_cmd_pkg::*;
#(
    parameter logic [7:0] RAM_TOP = 8'h6F,
    parameter logic [7:0] EE_BASE = 8'h80,
    parameter logic [7:0] EE_TOP  = 8'h9F
) (
    input  logic [7:0] cmd,
    output cmd_kind_t  kind
);

    always_comb begin
        if (cmd <= RAM_TOP)
            kind = CK_RAM;
        else if (cmd >= EE_BASE && cmd <= EE_TOP)
            kind = CK_EE;
        else
            kind = CK_BAD;
    end

endmodule

// File: rtl/smb_cmd_resolve.sv
module smb_cmd_resolve
    import smb_cmd_pkg::*;
(
    input  cmd_kind_t  kind,
    input  logic [1:0] cnt,
    input  logic       erase_mode,
    output op_t        op,
    output logic       cnt_full
);

    // Meaning of a finished write: command range x data byte count x mode
    always_comb begin
        op       = OP_NONE;
        cnt_full = 1'b1;
        unique case (kind)
            CK_RAM: begin
                cnt_full = (cnt >= 2'd1);
                if (cnt == 2'd0)      op = OP_RAM_PTR;
                else if (cnt == 2'd1) op = OP_RAM_WR;
            end
            CK_EE: begin
                cnt_full = (cnt >= 2'd2);
                if (cnt == 2'd1)      op = OP_EE_PTR;
                else if (cnt == 2'd2) op = erase_mode ? OP_EE_ERASE : OP_EE_PROG;
            end
            default: begin
                op       = OP_NONE;
                cnt_full = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/smb_cmd_decoder.sv
module smb_cmd_decoder
    import smb_cmd_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h2C,
    parameter logic [7:0] RAM_TOP    = 8'h6F,
    parameter logic [7:0] EE_BASE    = 8'h80,
    parameter logic [7:0] EE_TOP     = 8'h9F,
    parameter int         PAGE_OFS_W = 6,
    localparam int        RAM_AW     = $clog2(int'(RAM_TOP) + 1),
    localparam int        EE_HI_W    = $clog2(int'(EE_TOP - EE_BASE) + 1),
    localparam int        EE_AW      = EE_HI_W + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_byte,
    input  logic [7:0]        rx_byte,
    input  logic              mode_follow,
    input  logic              mode_erase,
    input  logic              ee_busy,
    output logic              resp_valid,
    output logic              resp_ack,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_waddr,
    output logic [7:0]        ram_wdata,
    output logic [RAM_AW-1:0] ram_ptr,
    output logic [EE_AW-1:0]  ee_ptr,
    output logic              ee_ptr_set,
    output logic              ptr_is_ee,
    output logic              rd_follow,
    output logic              ee_erase,
    output logic              ee_prog,
    output logic [EE_AW-1:0]  ee_op_addr,
    output logic [7:0]        ee_op_data
);

    localparam logic [EE_AW-1:0] PAGE_MASK = ~EE_AW'((1 << PAGE_OFS_W) - 1);

    phase_t     phase, phase_nx;
    cmd_kind_t  kind_rx, kind_q;
    op_t        op;
    logic [7:0] cmd_q, lo_q, dat_q;
    logic [1:0] cnt_q;
    logic       cnt_full, rsp_nx, ack_nx, commit, byte_only;
    logic [EE_AW-1:0] ee_addr_w;

    smb_cmd_classify #(
        .RAM_TOP (RAM_TOP),
        .EE_BASE (EE_BASE),
        .EE_TOP  (EE_TOP)
    ) u_class (
        .cmd  (rx_byte),
        .kind (kind_rx)
    );

    smb_cmd_resolve u_resolve (
        .kind       (kind_q),
        .cnt        (cnt_q),
        .erase_mode (mode_erase),
        .op         (op),
        .cnt_full   (cnt_full)
    );

    assign byte_only = ev_byte && !ev_start && !ev_stop;
    assign commit    = (ev_start || ev_stop) && (phase == PH_DATA);
    assign ee_addr_w = EE_AW'({8'(cmd_q - EE_BASE), lo_q});

    // Next state and per-byte ACK decision
    always_comb begin
        phase_nx = phase;
        rsp_nx   = 1'b0;
        ack_nx   = 1'b0;
        if (ev_start) begin
            phase_nx = PH_ADDR;
        end else if (ev_stop) begin
            phase_nx = PH_IDLE;
        end else if (ev_byte) begin
            unique case (phase)
                PH_ADDR: begin
                    rsp_nx = 1'b1;
                    if (rx_byte[7:1] == SLAVE_ADDR) begin
                        ack_nx   = 1'b1;
                        phase_nx = rx_byte[0] ? PH_READ : PH_CMD;
                    end else begin
                        phase_nx = PH_SKIP;
                    end
                end
                PH_CMD: begin
                    rsp_nx = 1'b1;
                    if (kind_rx == CK_BAD || (kind_rx == CK_EE && ee_busy)) begin
                        phase_nx = PH_SKIP;
                    end else begin
                        ack_nx   = 1'b1;
                        phase_nx = PH_DATA;
                    end
                end
                PH_DATA: begin
                    rsp_nx = 1'b1;
                    if (cnt_full || (kind_q == CK_EE && ee_busy))
                        phase_nx = PH_SKIP;
                    else
                        ack_nx = 1'b1;
                end
                default: phase_nx = phase;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    // Command and data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            lo_q   <= '0;
            dat_q  <= '0;
            cnt_q  <= '0;
            kind_q <= CK_BAD;
        end else if (byte_only && phase == PH_CMD) begin
            cmd_q  <= rx_byte;
            kind_q <= kind_rx;
            cnt_q  <= '0;
        end else if (byte_only && phase == PH_DATA && ack_nx) begin
            cnt_q <= cnt_q + 2'd1;
            if (cnt_q == 2'd0) lo_q  <= rx_byte;
            else               dat_q <= rx_byte;
        end
    end

    // Outputs: responses, pointers and request pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_ack   <= 1'b0;
            ram_we     <= 1'b0;
            ram_waddr  <= '0;
            ram_wdata  <= '0;
            ram_ptr    <= '0;
            ee_ptr     <= '0;
            ee_ptr_set <= 1'b0;
            ptr_is_ee  <= 1'b0;
            rd_follow  <= 1'b0;
            ee_erase   <= 1'b0;
            ee_prog    <= 1'b0;
            ee_op_addr <= '0;
            ee_op_data <= '0;
        end else begin
            resp_valid <= rsp_nx;
            resp_ack   <= ack_nx;
            ram_we     <= 1'b0;
            ee_ptr_set <= 1'b0;
            ee_erase   <= 1'b0;
            ee_prog    <= 1'b0;
            if (commit) begin
                unique case (op)
                    OP_RAM_PTR: begin
                        ram_ptr   <= cmd_q[RAM_AW-1:0];
                        ptr_is_ee <= 1'b0;
                    end
                    OP_RAM_WR: begin
                        ram_we    <= 1'b1;
                        ram_waddr <= cmd_q[RAM_AW-1:0];
                        ram_wdata <= lo_q;
                    end
                    OP_EE_PTR: begin
                        ee_ptr     <= ee_addr_w;
                        ee_ptr_set <= 1'b1;
                        ptr_is_ee  <= 1'b1;
                        rd_follow  <= mode_follow;
                    end
                    OP_EE_ERASE: begin
                        ee_erase   <= 1'b1;
                        ee_op_addr <= ee_addr_w & PAGE_MASK;
                    end
                    OP_EE_PROG: begin
                        ee_prog    <= 1'b1;
                        ee_op_addr <= ee_addr_w;
                        ee_op_data <= dat_q;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/smb_cmd_decoder_chk.sv
module smb_cmd_decoder_chk #(
    parameter logic [7:0] RAM_TOP    = 8'h6F,
    parameter int         PAGE_OFS_W = 6,
    parameter int         RAM_AW     = 7,
    parameter int         EE_AW      = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_start,
    input logic              ev_stop,
    input logic              ev_byte,
    input logic              resp_valid,
    input logic              ram_we,
    input logic [RAM_AW-1:0] ram_waddr,
    input logic [RAM_AW-1:0] ram_ptr,
    input logic [EE_AW-1:0]  ee_ptr,
    input logic              ee_ptr_set,
    input logic              ptr_is_ee,
    input logic              rd_follow,
    input logic              ee_erase,
    input logic              ee_prog,
    input logic [EE_AW-1:0]  ee_op_addr
);

    // R2
    resp_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(ev_byte));

    // R13
    single_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_we, ee_ptr_set, ee_erase, ee_prog}));

    // R13
    request_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || ee_ptr_set || ee_erase || ee_prog) |-> $past(ev_start || ev_stop));

    // R4
    ram_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_waddr <= RAM_TOP));

    // R3
    ram_ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ptr <= RAM_TOP);

    // R6
    erase_page_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_erase |-> (ee_op_addr[PAGE_OFS_W-1:0] == '0));

    // R5
    ee_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ee_ptr) |-> ee_ptr_set);

    // R5
    follow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_follow) |-> ee_ptr_set);

    // R11
    space_to_ee_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ptr_is_ee) |-> ee_ptr_set);

endmodule

bind smb_cmd_decoder smb_cmd_decoder_chk #(
    .RAM_TOP    (RAM_TOP),
    .PAGE_OFS_W (PAGE_OFS_W),
    .RAM_AW     (RAM_AW),
    .EE_AW      (EE_AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_start   (ev_start),
    .ev_stop    (ev_stop),
    .ev_byte    (ev_byte),
    .resp_valid (resp_valid),
    .ram_we     (ram_we),
    .ram_waddr  (ram_waddr),
    .ram_ptr    (ram_ptr),
    .ee_ptr     (ee_ptr),
    .ee_ptr_set (ee_ptr_set),
    .ptr_is_ee  (ptr_is_ee),
    .rd_follow  (rd_follow),
    .ee_erase   (ee_erase),
    .ee_prog    (ee_prog),
    .ee_op_addr (ee_op_addr)
);

// File: tb/smb_cmd_decoder_test.sv
`timescale 1ns/1ps
module smb_cmd_decoder_test;

    localparam logic [6:0] SA = 7'h2E;
    localparam logic [7:0] WR = {SA, 1'b0};
    localparam logic [7:0] RD = {SA, 1'b1};

    logic clk = 1'b0, rst_n = 1'b0;
    logic ev_start = 1'b0, ev_stop = 1'b0, ev_byte = 1'b0;
    logic [7:0] rx_byte = '0;
    logic mode_follow = 1'b0, mode_erase = 1'b0, ee_busy = 1'b0;
    logic resp_valid, resp_ack, ram_we, ee_ptr_set, ptr_is_ee, rd_follow, ee_erase, ee_prog;
    logic [6:0] ram_waddr, ram_ptr;
    logic [7:0] ram_wdata, ee_op_data;
    logic [12:0] ee_ptr, ee_op_addr;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    kind;   // 0 response, 1 RAM write, 2 EE pointer, 3 erase, 4 program
        int    addr;
        int    data;
        string req;
    } item_t;
    item_t q[$];

    always #2 clk = ~clk;

    smb_cmd_decoder #(.SLAVE_ADDR(SA)) uut (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_byte(ev_byte), .rx_byte(rx_byte), .mode_follow(mode_follow),
        .mode_erase(mode_erase), .ee_busy(ee_busy), .resp_valid(resp_valid),
        .resp_ack(resp_ack), .ram_we(ram_we), .ram_waddr(ram_waddr),
        .ram_wdata(ram_wdata), .ram_ptr(ram_ptr), .ee_ptr(ee_ptr),
        .ee_ptr_set(ee_ptr_set), .ptr_is_ee(ptr_is_ee), .rd_follow(rd_follow),
        .ee_erase(ee_erase), .ee_prog(ee_prog), .ee_op_addr(ee_op_addr),
        .ee_op_data(ee_op_data)
    );

    task automatic push(int k, int a, int d, string r);
        item_t it;
        it.kind = k; it.addr = a; it.data = d; it.req = r;
        q.push_back(it);
    endtask

    task automatic check_eq(string r, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    task automatic drive(logic s, logic p, logic b, logic [7:0] v);
        @(negedge clk);
        ev_start = s; ev_stop = p; ev_byte = b; rx_byte = v;
        @(negedge clk);
        ev_start = 1'b0; ev_stop = 1'b0; ev_byte = 1'b0;
    endtask

    task automatic do_start(); drive(1'b1, 1'b0, 1'b0, 8'h00); endtask
    task automatic do_stop();  drive(1'b0, 1'b1, 1'b0, 8'h00); endtask
    task automatic do_quiet(logic [7:0] v); drive(1'b0, 1'b0, 1'b1, v); endtask
    task automatic do_byte(logic [7:0] v, int ack, string r);
        push(0, 0, ack, r);
        drive(1'b0, 1'b0, 1'b1, v);
    endtask

    // Monitor: pops the scoreboard on every response or request
    task automatic compare(int k, int a, int d);
        item_t it;
        checks++;
        if (q.size() == 0) begin
            errors++;
            $display("FAIL R2 unexpected output actual kind=%0d addr=%0h data=%0h expected none", k, a, d);
        end else begin
            it = q.pop_front();
            if (it.kind != k || it.addr != a || it.data != d) begin
                errors++;
                $display("FAIL %s actual kind=%0d addr=%0h data=%0h expected kind=%0d addr=%0h data=%0h",
                         it.req, k, a, d, it.kind, it.addr, it.data);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (resp_valid) compare(0, 0, int'(resp_ack));
            if ((int'(ram_we) + int'(ee_ptr_set) + int'(ee_erase) + int'(ee_prog)) > 1) begin
                checks++;
                errors++;
                $display("FAIL R13 several requests in one cycle actual=%b expected one-hot",
                         {ram_we, ee_ptr_set, ee_erase, ee_prog});
            end else if (ram_we)     compare(1, int'(ram_waddr), int'(ram_wdata));
            else if (ee_ptr_set)     compare(2, int'(ee_ptr), 0);
            else if (ee_erase)       compare(3, int'(ee_op_addr), 0);
            else if (ee_prog)        compare(4, int'(ee_op_addr), int'(ee_op_data));
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R13, R2)
        check_eq("R2", "resp_valid after reset", int'(resp_valid), 0);
        check_eq("R3", "ram_ptr after reset", int'(ram_ptr), 0);
        check_eq("R5", "ee_ptr after reset", int'(ee_ptr), 0);
        check_eq("R11", "ptr_is_ee after reset", int'(ptr_is_ee), 0);

        // R3: command only
        do_start(); do_byte(WR, 1, "R1"); do_byte(8'h6F, 1, "R3"); do_stop();
        check_eq("R3", "ram_ptr", int'(ram_ptr), 'h6F);

        // R4: one data byte writes RAM
        do_start(); do_byte(WR, 1, "R1"); do_byte(8'h10, 1, "R4"); do_byte(8'hA5, 1, "R4");
        push(1, 'h10, 'hA5, "R4"); do_stop();

        // R4: second data byte NACKed, nothing written
        do_start(); do_byte(WR, 1, "R1"); do_byte(8'h20, 1, "R4"); do_byte(8'h11, 1, "R4");
        do_byte(8'h22, 0, "R4"); do_quiet(8'h23); do_stop();

        // R9: reserved command ranges
        do_start(); do_byte(WR, 1, "R1"); do_byte(8'h70, 0, "R9"); do_quiet(8'h33); do_stop();
        do_start(); do_byte(WR, 1, "R1"); do_byte(8'h7F, 0, "R9"); do_stop();
        do_start(); do_byte(WR, 1, "R1"); do_byte(8'hA0, 0, "R9"); do_quiet(8'h01); do_stop();
        do_start(); do_byte(WR, 1, "R1"); do_byte(8'hFF, 0, "R9"); do_stop();
        check_eq("R9", "ram_ptr unchanged", int'(ram_ptr), 'h6F);
        check_eq("R9", "ee_ptr unchanged", int'(ee_ptr), 0);

        // R1: foreign address, everything after ignored
        do_start(); do_byte(8'h40, 0, "R1"); do_quiet(8'h10); do_quiet(8'h55); do_stop();
        check_eq("R1", "ram_ptr unchanged", int'(ram_ptr), 'h6F);

        // R2: byte outside any transaction gets no response
        do_quiet(8'h11);

        // R5: EEPROM pointer set, follow mode recorded
        mode_follow = 1'b1;
        do_start(); do_byte(WR, 1, "R1"); do_byte(8'h9F, 1, "R5"); do_byte(8'hC3, 1, "R5");
        push(2, 'h1FC3, 0, "R5"); do_stop();
        check_eq("R5", "ee_ptr", int'(ee_ptr), 'h1FC3);
        check_eq("R5", "ptr_is_ee", int'(ptr_is_ee), 1);
        check_eq("R5", "rd_follow", int'(rd_follow), 1);

        // R11: repeated start commits the EEPROM pointer, read keeps it
        mode_follow = 1'b0;
        do_start(); do_byte(WR, 1, "R1"); do_byte(8'h80, 1, "R11"); do_byte(8'h07, 1, "R11");
        push(2, 'h0007, 0, "R11"); do_start();
        do_byte(RD, 1, "R11"); do_quiet(8'h5A); do_stop();
        check_eq("R11", "ee_ptr", int'(ee_ptr), 'h0007);
        check_eq("R11", "rd_follow", int'(rd_follow), 0);
        check_eq("R11", "ptr_is_ee", int'(ptr_is_ee), 1);

        // R11: repeated start commits the RAM pointer
        do_start(); do_byte(WR, 1, "R1"); do_byte(8'h05, 1, "R11"); do_start();
        do_byte(RD, 1, "R11"); do_quiet(8'h66); do_stop();
        check_eq("R11", "ram_ptr", int'(ram_ptr), 'h05);
        check_eq("R11", "ptr_is_ee back to RAM", int'(ptr_is_ee), 0);

        // R6: page erase
        mode_erase = 1'b1;
        do_start(); do_byte(WR, 1, "R1"); do_byte(8'h81, 1, "R6"); do_byte(8'h7F, 1, "R6");
        do_byte(8'hAA, 1, "R6"); push(3, 'h0140, 0, "R6"); do_stop();

        // R7: byte program
        mode_erase = 1'b0;
        do_start(); do_byte(WR, 1, "R1"); do_byte(8'h85, 1, "R7"); do_byte(8'h12, 1, "R7");
        do_byte(8'h34, 1, "R7"); push(4, 'h0512, 'h34, "R7"); do_stop();
        check_eq("R7", "ee_ptr untouched by program", int'(ee_ptr), 'h0007);

        // R8: third data byte cancels
        do_start(); do_byte(WR, 1, "R1"); do_byte(8'h85, 1, "R8"); do_byte(8'h12, 1, "R8");
        do_byte(8'h34, 1, "R8"); do_byte(8'h56, 0, "R8"); do_stop();

        // R10: busy EEPROM
        ee_busy = 1'b1;
        do_start(); do_byte(WR, 1, "R1"); do_byte(8'h85, 0, "R10"); do_quiet(8'h12); do_stop();
        ee_busy = 1'b0;
        do_start(); do_byte(WR, 1, "R1"); do_byte(8'h85, 1, "R10");
        ee_busy = 1'b1;
        do_byte(8'h12, 0, "R10"); do_stop();
        do_start(); do_byte(WR, 1, "R1"); do_byte(8'h30, 1, "R10"); do_byte(8'h99, 1, "R10");
        push(1, 'h30, 'h99, "R10"); do_stop();
        ee_busy = 1'b0;
        check_eq("R10", "ee_ptr unchanged", int'(ee_ptr), 'h0007);

        // R12: EEPROM command with no data
        do_start(); do_byte(WR, 1, "R1"); do_byte(8'h90, 1, "R12"); do_stop();
        check_eq("R12", "ee_ptr unchanged", int'(ee_ptr), 'h0007);
        check_eq("R12", "ptr_is_ee unchanged", int'(ptr_is_ee), 0);

        repeat (4) @(negedge clk);
        check_eq("R2", "outstanding expected items", q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule